// File: doc/BRIEF.md
# Switch-Programmable AND-OR Logic Array

This block is a small programmable sum-of-products array. Four primary inputs are each offered in true and complemented form, which gives eight literals. Each of four product terms is the AND of whichever literals its switches enable. A literal whose switch is off does not drop out of the gate. Its input to the AND is tied high instead. A term with every switch off therefore evaluates to 1. A fixed OR plane then forms the OR of every unordered pair of terms. The four raw terms are also brought out, so the block has ten outputs in all.

The 32 switches are held in a stored configuration word. The word is written whole through a 32-bit data port when a write strobe is high at a clock edge. All outputs are combinational functions of the primary inputs and the stored word. A new word therefore takes effect at the clock edge that stores it.

Top module: `sw_and_or_array`

## Requirements
- R1: During and after reset, before any write, the stored word is all zeros: every switch is off, and all four term outputs and all six pair outputs are 1 for every input value.
- R2: Switch bit 8*t+2*k of the word enables the true literal of in_vec[k] in term t. Bit 8*t+2*k+1 enables the complemented literal of in_vec[k] in the same term (t and k run from 0 to 3).
- R3: A literal whose switch bit is 0 contributes logic 1, so a term whose eight switch bits are all 0 outputs 1.
- R4: term_out[t] is the AND of its enabled literals. A term that enables both forms of the same input always outputs 0.
- R5: pair_out[p] is the OR of two terms, with p = 0..5 mapped to term pairs (0,1), (0,2), (0,3), (1,2), (1,3), (2,3).
- R6: term_out carries the four product terms before the OR plane, with bit t equal to term t.
- R7: When cfg_we is 1 at a rising clock edge, cfg_data is stored. Outputs follow the old word up to that edge and the new word after it.
- R8: When cfg_we is 0, cfg_data has no effect on the stored word or on the outputs.
- R9: If term 0 enables only the true form of in_vec[0], term 1 enables only the complement of in_vec[1], and the other terms have all switches off, then pair_out[0] is 1, 1, 0, 1 for (in_vec[0], in_vec[1]) = 00, 10, 01, 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low asynchronous reset; clears the stored word |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 32 | New switch word |
| in_vec | input | 4 | Primary inputs |
| term_out | output | 4 | Raw product terms |
| pair_out | output | 6 | Pairwise ORs of the product terms |

## Verification
A wrong bit in the stored word is a switch in the wrong position. It shows on the affected term output, and on the three pair outputs that use that term, as soon as an input value exercises that literal. Because the outputs are combinational from the register, the fault is visible in the same cycle as that input value. Sweeping all sixteen input values after every write exposes any such bit at once. A write that lands one edge early or late shows as old or new behaviour on the wrong side of that edge.

// File: rtl/sw_and_or_array.sv
module sw_and_or_array #(
  parameter int NUM_IN    = 4,
  parameter int NUM_TERMS = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      cfg_we,
  input  logic [2*NUM_IN*NUM_TERMS-1:0]             cfg_data,
  input  logic [NUM_IN-1:0]                         in_vec,
  output logic [NUM_TERMS-1:0]                      term_out,
  output logic [NUM_TERMS*(NUM_TERMS-1)/2-1:0]      pair_out
);
  localparam int LIT   = 2 * NUM_IN;
  localparam int CFG_W = LIT * NUM_TERMS;

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] lit_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_data;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    for (genvar k = 0; k < NUM_IN; k++) begin : g_lit
      assign lit_ok[t*LIT+2*k]   = ~cfg_q[t*LIT+2*k]   |  in_vec[k];
      assign lit_ok[t*LIT+2*k+1] = ~cfg_q[t*LIT+2*k+1] | ~in_vec[k];

      // R4
      conflict_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[t*LIT+2*k] && cfg_q[t*LIT+2*k+1]) |-> !term_out[t]);
    end
    assign term_out[t] = &lit_ok[t*LIT +: LIT];

    // R3
    all_off_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[t*LIT +: LIT] == '0) |-> term_out[t]);
  end

  for (genvar a = 0; a < NUM_TERMS; a++) begin : g_pa
    for (genvar b = a + 1; b < NUM_TERMS; b++) begin : g_pb
      assign pair_out[a*(2*NUM_TERMS-a-1)/2 + b-a-1] = term_out[a] | term_out[b];
    end
  end

  // R5
  pair_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_out == '0) |-> (pair_out == '0));

  // R7
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_data)));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));
endmodule

// File: tb/sw_and_or_array_tb.sv
module sw_and_or_array_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_data = '0;
  logic [3:0]  in_vec = '0;
  logic [3:0]  term_out;
  logic [5:0]  pair_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sw_and_or_array u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
                         .in_vec(in_vec), .term_out(term_out), .pair_out(pair_out));

  function automatic logic [9:0] model(input logic [31:0] w, input logic [3:0] x);
    logic [3:0] tv;
    logic [5:0] pv;
    int p;
    for (int t = 0; t < 4; t++) begin
      tv[t] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        if (w[8*t+2*k]   && !x[k]) tv[t] = 1'b0;
        if (w[8*t+2*k+1] &&  x[k]) tv[t] = 1'b0;
      end
    end
    p = 0;
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++) begin
        pv[p] = tv[a] | tv[b];
        p++;
      end
    return {pv, tv};
  endfunction

  task automatic check(input string req, input logic [9:0] exp);
    checks++;
    if ({pair_out, term_out} !== exp) begin
      errors++;
      $display("FAIL %s in=%b act=%b exp=%b", req, in_vec, {pair_out, term_out}, exp);
    end
  endtask

  task automatic sweep(input string req, input logic [31:0] w);
    for (int i = 0; i < 16; i++) begin
      in_vec = 4'(i);
      #0.5;
      check(req, model(w, in_vec));
    end
  endtask

  task automatic write_cfg(input logic [31:0] w, input logic [31:0] prev);
    @(negedge clk);
    cfg_we = 1; cfg_data = w;
    #0.5;
    check("R7 before edge", model(prev, in_vec));
    @(negedge clk);
    cfg_we = 0;
    cfg_data = $urandom;
    #0.5;
    check("R7 after edge", model(w, in_vec));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] cur, w;
    void'($urandom(32'd1234));
    #5;
    sweep("R1 in reset", 32'h0);
    @(negedge clk); rst_n = 1;
    sweep("R1 after reset", 32'h0);
    for (int i = 0; i < 16; i++) begin
      in_vec = 4'(i); #0.5;
      checks++;
      if (term_out !== 4'hF || pair_out !== 6'h3F) begin
        errors++; $display("FAIL R3 all-off act=%b exp=%b", {pair_out, term_out}, 10'h3FF);
      end
    end
    cur = 32'h0;
    // R9: term0 = in_vec[0] true (bit 0), term1 = ~in_vec[1] (bit 8+3)
    w = 32'h0000_0801;
    write_cfg(w, cur); cur = w;
    begin
      logic [3:0] ins [4] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011};
      logic       exp [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
      for (int i = 0; i < 4; i++) begin
        in_vec = ins[i]; #0.5; checks++;
        if (pair_out[0] !== exp[i]) begin
          errors++; $display("FAIL R9 act=%b exp=%b", pair_out[0], exp[i]);
        end
      end
    end
    // R2 R6: single-literal terms
    w = 32'h4010_0401;
    write_cfg(w, cur); cur = w;
    sweep("R2 R6 single literals", w);
    // R4: conflicting literals in term 2
    w = 32'h0003_0000;
    write_cfg(w, cur); cur = w;
    for (int i = 0; i < 16; i++) begin
      in_vec = 4'(i); #0.5; checks++;
      if (term_out[2] !== 1'b0) begin
        errors++; $display("FAIL R4 conflict act=%b exp=0", term_out[2]);
      end
    end
    // R5: all terms full minterms
    w = 32'h5599_66AA;
    write_cfg(w, cur); cur = w;
    sweep("R5 pair order", w);
    // R8: data without strobe
    for (int r = 0; r < 20; r++) begin
      @(negedge clk); cfg_data = $urandom; cfg_we = 0;
      @(negedge clk);
      sweep("R8 ignored data", cur);
    end
    // random
    for (int r = 0; r < 300; r++) begin
      w = $urandom & $urandom;
      write_cfg(w, cur); cur = w;
      sweep("R4 R5 random", w);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule